// File: doc/BRIEF.md
# Dual-Path Bit-Rate Tick Generator

This block produces the bit-rate enable for a serial transmitter and receiver. One configuration word, loaded through a single-cycle write strobe, holds three things: a divisor, a bit that chooses between that divisor and a built-in default, and a bit that chooses the clock path.

Both clock paths are modelled as clock enables inside one clock domain. On the crystal path, a fixed divide-by-3 stage runs ahead of the programmable divider. On the other path, a fixed divide-by-4 stage runs ahead of it. The output is a pulse one clock wide, issued once per bit period. Every write restarts the count, so the new rate takes effect cleanly from the moment of the write.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the tick is low, and the generator runs on the default divisor (parameter, 15) on the divide-by-4 path. The first tick appears 4*(15+1) = 64 cycles after reset is released and repeats with that period.
- R2: When configuration bit 24 is 1 (crystal path), the tick period is 3*(d+1) clock cycles, where d is the effective divisor.
- R3: When configuration bit 24 is 0, the tick period is 4*(d+1) clock cycles.
- R4: When configuration bit 23 is 0, the divisor field in bits 22:0 has no effect and the default divisor 15 is used. Bit 24 still selects the path.
- R5: When configuration bit 23 is 1, the effective divisor d is the value in bits 22:0.
- R6: A write restarts the count. The first tick after a write appears exactly one full new period after the write edge, and no tick appears before it.
- R7: The tick is high for exactly one clock cycle per period.
- R8: A divisor of 0 is legal. It gives a period of 3 cycles on the crystal path and 4 cycles on the other path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | One-cycle write strobe for the configuration word |
| cfg_wdata | input | 25 | Bits 22:0 divisor, bit 23 use divisor, bit 24 crystal path |
| tick | output | 1 | One-cycle bit-rate enable pulse |

## Verification
Directed words cover the following cases:
- Divisor 0 on both paths, which separates the two prescale factors at their tightest.
- Use-divisor cleared while the divisor field holds a non-default value, which shows whether the field leaks through.
- A rewrite in the middle of a period, which shows whether the count truly restarts or carries over the old phase.

Random words mix both selection bits with small divisors. Their measured periods separate the (d+1) scaling from the prescale factor. For every word, the bench checks the position of the first tick, then two more periods, and confirms that no pulse appears in between.

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int unsigned DIV_W     = 23,
  parameter int unsigned DEF_DIV   = 15,
  parameter int unsigned XTAL_PRE  = 3,
  parameter int unsigned PLAIN_PRE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [DIV_W+1:0] cfg_wdata,
  output logic             tick
);
  localparam int unsigned USE_BIT = DIV_W;
  localparam int unsigned SRC_BIT = DIV_W + 1;
  localparam int unsigned PRE_MAX = (XTAL_PRE > PLAIN_PRE) ? XTAL_PRE : PLAIN_PRE;
  localparam int unsigned PRE_W   = (PRE_MAX > 2) ? $clog2(PRE_MAX) : 1;
  localparam logic [DIV_W-1:0] DEF_V    = DEF_DIV[DIV_W-1:0];
  localparam logic [PRE_W-1:0] XTAL_TOP = PRE_W'(XTAL_PRE - 1);
  localparam logic [PRE_W-1:0] PLN_TOP  = PRE_W'(PLAIN_PRE - 1);

  logic [DIV_W-1:0] div_q;
  logic             use_q, xtal_q;
  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic             tick_q;

  wire [DIV_W-1:0] eff_div  = use_q ? div_q : DEF_V;
  wire [PRE_W-1:0] pre_top  = xtal_q ? XTAL_TOP : PLN_TOP;
  wire             pre_wrap = (pre_cnt == pre_top);
  wire             div_wrap = (div_cnt == eff_div);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= DEF_V;
      use_q   <= 1'b0;
      xtal_q  <= 1'b0;
      pre_cnt <= '0;
      div_cnt <= '0;
      tick_q  <= 1'b0;
    end else if (cfg_we) begin
      div_q   <= cfg_wdata[DIV_W-1:0];
      use_q   <= cfg_wdata[USE_BIT];
      xtal_q  <= cfg_wdata[SRC_BIT];
      pre_cnt <= '0;
      div_cnt <= '0;
      tick_q  <= 1'b0;
    end else begin
      tick_q <= pre_wrap && div_wrap;
      if (pre_wrap) begin
        pre_cnt <= '0;
        div_cnt <= div_wrap ? '0 : div_cnt + 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end

  assign tick = tick_q;

  // R7
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R6
  reload_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !tick);

  // R2
  pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt <= pre_top);

  // R3
  tick_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (pre_cnt == '0) && (div_cnt == '0));

  // R5
  div_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt <= eff_div);
endmodule

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [24:0] cfg_wdata = '0;
  logic        tick;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  baud_tick_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .tick(tick)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  function automatic int exp_period(logic [24:0] w);
    int d = w[23] ? int'(w[22:0]) : 15;
    return (w[24] ? 3 : 4) * (d + 1);
  endfunction

  task automatic observe(string req, int p);
    int first = -1;
    int got = 0;
    int stray = 0;
    for (int k = 1; k <= 3 * p + 2; k++) begin
      @(negedge clk);
      if (tick) begin
        if (first < 0) first = k;
        if (k == (got + 1) * p) got++;
        else stray++;
      end
    end
    check(first == p, {req, " first tick"}, first, p);
    check(got == 3 && stray == 0, {req, " periodic single pulses"}, got * 100 + stray, 300);
  endtask

  task automatic write_cfg(logic [24:0] w);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    check(tick == 1'b0, "R1 tick low in reset", int'(tick), 0);
    rst_n = 1'b1;
    observe("R1 default after reset", 64);

    write_cfg({1'b1, 1'b1, 23'd0});
    observe("R8 R2 divisor 0 crystal", 3);
    write_cfg({1'b0, 1'b1, 23'd0});
    observe("R8 R3 divisor 0 plain", 4);

    write_cfg({1'b0, 1'b0, 23'd7});
    observe("R4 use bit clear plain", 64);
    write_cfg({1'b1, 1'b0, 23'd2});
    observe("R4 use bit clear crystal", 48);

    write_cfg({1'b0, 1'b1, 23'd9});
    observe("R5 R3 divisor 9 plain", 40);
    write_cfg({1'b1, 1'b1, 23'd9});
    observe("R5 R2 divisor 9 crystal", 30);

    write_cfg({1'b0, 1'b1, 23'd20});
    repeat (30) @(negedge clk);
    write_cfg({1'b1, 1'b1, 23'd5});
    observe("R6 rewrite mid period", 18);

    for (int i = 0; i < 16; i++) begin
      logic [24:0] w;
      w = {$urandom_range(1, 0) == 1, $urandom_range(1, 0) == 1, 23'($urandom_range(40, 0))};
      write_cfg(w);
      observe($sformatf("R7 R2 R3 random word %0h", w), exp_period(w));
    end

    done = 1;
    finish_run();
  end
endmodule